// File: doc/BRIEF.md
# Processor Frequency Strap Driver

This block sets the processor's core-frequency strap values around processor reset. It uses four shared lines that normally carry functional interrupt and gate signals, so no external strap logic is needed. While the platform is held in reset, the block drives all four lines high. When power-good is first seen high, the block samples a 4-bit strap register.

What happens next depends on the power state being left. For mechanical-off and for the deeper sleep states, the processor is reset. In that case the sampled value is placed on the lines, platform reset is released after a setup window, and the value is held for a further window. The lines are then handed back to their functional sources through an output-enable.

Leaving the light sleep state involves no processor reset. In that case the strap sequence is skipped and the lines are not driven. A reset request forces the reset state at any time. The following release always runs the full strap sequence.

Top module: `cpu_strap_drv`

## Requirements
- R1: While `rst` is high, and on the clock after it, `plat_rst`=1, `line_oe`=1 and `line_val`=4'hF.
- R2: When `pwr_good` is low or `rst_req` is high at a rising clock edge, the outputs after that edge are `plat_rst`=1, `line_oe`=1 and `line_val`=4'hF, whatever state the block was in.
- R3: `strap_reg` is sampled only at the edge where `pwr_good` is first seen high (with `rst_req` low) in the reset state. Later changes of `strap_reg` do not alter `line_val`.
- R4: `exit_state` is 3 bits, and only code 1 (light sleep) skips the straps. Codes 0, 3, 4 and 5 (mechanical-off and deep sleep) run the strap sequence, and so do the undefined codes 2, 6 and 7. In that sequence, the outputs after the sampling edge are `line_val[i]`=`strap_reg[i]` for each bit i, with `plat_rst`=1 and `line_oe`=1.
- R5: `plat_rst` goes low `SETUP_CLKS` (default 4) edges after the strap values first appear. The strap value and `line_oe`=1 do not change at that point.
- R6: After `plat_rst` goes low, `line_val` keeps the strap value with `line_oe`=1 for `HOLD_CLKS` (default 8) edges. After that, `line_oe`=0 and `line_val`=0.
- R7: With `exit_state`=1 and no pending reset request, the outputs after the sampling edge are `plat_rst`=0, `line_oe`=0 and `line_val`=0. These outputs stay that way.
- R8: After `rst_req` has been high, the next release runs the strap sequence of R4 to R6 even if `exit_state`=1. The pending request is cleared once the straps are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Power-good indication |
| rst_req | input | 1 | Request to reset the processor |
| exit_state | input | 3 | Code of the power state being left |
| strap_reg | input | 4 | Strap register contents |
| line_val | output | 4 | Values for the four shared lines |
| line_oe | output | 1 | High while this block owns the lines |
| plat_rst | output | 1 | Platform reset, active high |

## Verification
The assertions check four things on every cycle:
- a power-good loss or a reset request is followed by the all-high reset outputs;
- the sampled strap value appears one edge after sampling;
- the setup and hold windows are at least their configured lengths, and the value stays stable during the hold window;
- a skipped sequence only ever follows the light-sleep code.

Only the bench scenarios show the following:
- the exact edge counts of each window, for every exit code;
- that strap changes after sampling are ignored;
- that a pending reset request overrides the light-sleep bypass and is cleared afterwards.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int EXIT_W = 3;
  localparam logic [EXIT_W-1:0] EXIT_LIGHT = 3'd1;

  typedef enum logic [1:0] {
    ST_PORST = 2'd0,
    ST_SETUP = 2'd1,
    ST_HOLD  = 2'd2,
    ST_RUN   = 2'd3
  } strap_st_e;

  function automatic logic exit_resets_cpu(input logic [EXIT_W-1:0] code);
    return code != EXIT_LIGHT;
  endfunction
endpackage

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int LINES_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       capture,
  input  logic                       rst_req,
  input  logic [strap_pkg::EXIT_W-1:0] exit_state,
  input  logic [LINES_W-1:0]         strap_in,
  output logic [LINES_W-1:0]         strap_nxt,
  output logic                       drive_straps
);
  logic [LINES_W-1:0] strap_q;
  logic               req_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      strap_q  <= '0;
      req_pend <= 1'b0;
    end else begin
      if (capture) strap_q <= strap_in;
      if (rst_req) req_pend <= 1'b1;
      else if (capture) req_pend <= 1'b0;
    end
  end

  assign strap_nxt    = capture ? strap_in : strap_q;
  assign drive_straps = strap_pkg::exit_resets_cpu(exit_state) || req_pend;
endmodule

// File: rtl/strap_timer.sv
module strap_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/strap_seq.sv
module strap_seq
  import strap_pkg::*;
#(
  parameter int SETUP_CLKS = 4,
  parameter int HOLD_CLKS  = 8,
  parameter int CNT_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_good,
  input  logic             rst_req,
  input  logic             drive_straps,
  input  logic             tmr_done,
  output strap_st_e        st,
  output strap_st_e        st_nxt,
  output logic             capture,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);
  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CLKS - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CLKS - 1);

  always_comb begin
    st_nxt   = st;
    capture  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (!pwr_good || rst_req) begin
      st_nxt = ST_PORST;
    end else begin
      case (st)
        ST_PORST: begin
          capture = 1'b1;
          if (drive_straps) begin
            st_nxt   = ST_SETUP;
            tmr_load = 1'b1;
            tmr_val  = SETUP_LAST;
          end else begin
            st_nxt = ST_RUN;
          end
        end
        ST_SETUP: if (tmr_done) begin
          st_nxt   = ST_HOLD;
          tmr_load = 1'b1;
          tmr_val  = HOLD_LAST;
        end
        ST_HOLD:  if (tmr_done) st_nxt = ST_RUN;
        default:  st_nxt = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_PORST;
    else     st <= st_nxt;
  end
endmodule

// File: rtl/cpu_strap_drv.sv
module cpu_strap_drv
  import strap_pkg::*;
#(
  parameter int LINES_W    = 4,
  parameter int SETUP_CLKS = 4,
  parameter int HOLD_CLKS  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pwr_good,
  input  logic               rst_req,
  input  logic [EXIT_W-1:0]  exit_state,
  input  logic [LINES_W-1:0] strap_reg,
  output logic [LINES_W-1:0] line_val,
  output logic               line_oe,
  output logic               plat_rst
);
  localparam int MAX_WIN = (SETUP_CLKS > HOLD_CLKS) ? SETUP_CLKS : HOLD_CLKS;
  localparam int CNT_W   = $clog2(MAX_WIN + 1);

  strap_st_e          st, st_nxt;
  logic               capture, drive_straps, tmr_load, tmr_done;
  logic [CNT_W-1:0]   tmr_val;
  logic [LINES_W-1:0] strap_nxt;

  strap_latch #(.LINES_W(LINES_W)) i_latch (
    .clk(clk), .rst(rst), .capture(capture), .rst_req(rst_req),
    .exit_state(exit_state), .strap_in(strap_reg),
    .strap_nxt(strap_nxt), .drive_straps(drive_straps)
  );

  strap_timer #(.CNT_W(CNT_W)) i_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  strap_seq #(.SETUP_CLKS(SETUP_CLKS), .HOLD_CLKS(HOLD_CLKS), .CNT_W(CNT_W)) i_seq (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .rst_req(rst_req),
    .drive_straps(drive_straps), .tmr_done(tmr_done),
    .st(st), .st_nxt(st_nxt), .capture(capture),
    .tmr_load(tmr_load), .tmr_val(tmr_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      plat_rst <= 1'b1;
      line_oe  <= 1'b1;
      line_val <= '1;
    end else begin
      case (st_nxt)
        ST_PORST: begin plat_rst <= 1'b1; line_oe <= 1'b1; line_val <= '1;        end
        ST_SETUP: begin plat_rst <= 1'b1; line_oe <= 1'b1; line_val <= strap_nxt; end
        ST_HOLD:  begin plat_rst <= 1'b0; line_oe <= 1'b1; line_val <= strap_nxt; end
        default:  begin plat_rst <= 1'b0; line_oe <= 1'b0; line_val <= '0;        end
      endcase
    end
  end
endmodule

// File: rtl/cpu_strap_drv_chk.sv
module cpu_strap_drv_chk
  import strap_pkg::*;
#(
  parameter int LINES_W    = 4,
  parameter int SETUP_CLKS = 4,
  parameter int HOLD_CLKS  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               pwr_good,
  input logic               rst_req,
  input logic [EXIT_W-1:0]  exit_state,
  input logic [LINES_W-1:0] strap_reg,
  input logic [LINES_W-1:0] line_val,
  input logic               line_oe,
  input logic               plat_rst,
  input strap_st_e          st
);
  localparam int WIN_W = $clog2(SETUP_CLKS + HOLD_CLKS + 2);
  logic [WIN_W-1:0] setup_cyc, hold_cyc;

  always_ff @(posedge clk) begin
    if (rst) begin
      setup_cyc <= '0;
      hold_cyc  <= '0;
    end else begin
      setup_cyc <= (st == ST_SETUP) ? ((setup_cyc == '1) ? setup_cyc : setup_cyc + 1'b1) : '0;
      hold_cyc  <= (st == ST_HOLD)  ? ((hold_cyc  == '1) ? hold_cyc  : hold_cyc  + 1'b1) : '0;
    end
  end

  p_force_reset_r2: assert property (@(posedge clk) disable iff (rst)
    (!pwr_good || rst_req) |=> (plat_rst && line_oe && line_val == '1));

  p_strap_sample_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PORST && pwr_good && !rst_req && exit_state != EXIT_LIGHT)
      |=> (plat_rst && line_oe && line_val == $past(strap_reg)));

  p_setup_window_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(plat_rst) && line_oe) |-> (setup_cyc >= WIN_W'(SETUP_CLKS)));

  p_hold_window_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(line_oe) && !$past(plat_rst)) |-> (hold_cyc >= WIN_W'(HOLD_CLKS)));

  p_hold_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (line_oe && !plat_rst) |-> $stable(line_val));

  p_released_r6: assert property (@(posedge clk) disable iff (rst)
    !line_oe |-> (!plat_rst && line_val == '0));

  p_bypass_only_light_r7: assert property (@(posedge clk) disable iff (rst)
    ($fell(plat_rst) && !line_oe) |-> ($past(exit_state) == EXIT_LIGHT));

  always_comb begin
    if (!rst && line_oe == 1'b0) begin
      a_no_reset_when_released_r6: assert (plat_rst == 1'b0);
    end
  end
endmodule

bind cpu_strap_drv cpu_strap_drv_chk #(
  .LINES_W(LINES_W), .SETUP_CLKS(SETUP_CLKS), .HOLD_CLKS(HOLD_CLKS)
) i_chk (
  .clk(clk), .rst(rst), .pwr_good(pwr_good), .rst_req(rst_req),
  .exit_state(exit_state), .strap_reg(strap_reg), .line_val(line_val),
  .line_oe(line_oe), .plat_rst(plat_rst), .st(st)
);

// File: tb/test_cpu_strap_drv.sv
`timescale 1ns/1ps
module test_cpu_strap_drv;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwr_good = 1'b0;
  logic       rst_req = 1'b0;
  logic [2:0] exit_state = 3'd0;
  logic [3:0] strap_reg = 4'h0;
  logic [3:0] line_val;
  logic       line_oe, plat_rst;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cpu_strap_drv i_cpu_strap_drv (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .rst_req(rst_req),
    .exit_state(exit_state), .strap_reg(strap_reg),
    .line_val(line_val), .line_oe(line_oe), .plat_rst(plat_rst)
  );

  // {skip, exit_state[2:0], strap[3:0]}
  localparam logic [7:0] VEC [8] = '{
    8'h0_5, 8'h9_A, 8'h2_3, 8'h3_C, 8'h4_6, 8'h5_9, 8'h6_1, 8'h7_E
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [5:0] exp);
    logic [5:0] act;
    act = {plat_rst, line_oe, line_val};
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: {rst,oe,val} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic strap_tail(input logic [3:0] s);
    for (int j = 1; j < 4; j++) begin step(); chk("R5 setup", {2'b11, s}); end
    step(); chk("R5 release", {2'b01, s});
    for (int j = 1; j < 8; j++) begin step(); chk("R6 hold", {2'b01, s}); end
    step(); chk("R6 handback", 6'b00_0000);
  endtask

  task automatic run_seq(input logic skip, input logic [2:0] code, input logic [3:0] s);
    pwr_good = 1'b0;
    step(); chk("R2 pwr low", 6'b11_1111);
    exit_state = code; strap_reg = s; pwr_good = 1'b1;
    step();
    if (skip) begin
      chk("R7 bypass", 6'b00_0000);
      step(); chk("R7 stays", 6'b00_0000);
    end else begin
      chk("R4 straps", {2'b11, s});
      strap_reg = ~s; // R3: ignored after sampling
      strap_tail(s);
    end
  endtask

  initial begin
    // R1 reset state
    step(); step();
    chk("R1 in reset", 6'b11_1111);
    rst = 1'b0;
    step(); chk("R1 after reset", 6'b11_1111);

    for (int i = 0; i < 8; i++) begin
      run_seq(VEC[i][7], VEC[i][6:4], VEC[i][3:0]);
    end

    // R2: power loss in the middle of the hold window
    pwr_good = 1'b0; step();
    exit_state = 3'd3; strap_reg = 4'h6; pwr_good = 1'b1;
    step(); chk("R4 straps", 6'b11_0110);
    for (int j = 0; j < 6; j++) step();
    chk("R6 mid hold", 6'b01_0110);
    pwr_good = 1'b0;
    step(); chk("R2 drop in hold", 6'b11_1111);

    // R8: reset request overrides the light-sleep bypass
    pwr_good = 1'b1; exit_state = 3'd1; strap_reg = 4'hB; rst_req = 1'b1;
    step(); chk("R8 req holds reset", 6'b11_1111);
    step(); chk("R8 req holds reset", 6'b11_1111);
    rst_req = 1'b0;
    step(); chk("R8 straps despite light", 6'b11_1011);
    strap_reg = 4'h0;
    strap_tail(4'hB);

    // R8: request cleared after sampling, next light exit bypasses
    run_seq(1'b1, 3'd1, 4'h7);

    // R2: request during normal running
    rst_req = 1'b1;
    step(); chk("R2 req in run", 6'b11_1111);
    rst_req = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule